// File: doc/BRIEF.md
# MDIO Management Access Controller

This block turns one register-mapped management request at a time into a Clause-22 serial management frame on a clock/data pair toward external PHY devices. Software writes a single access word holding a start flag, a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The controller builds the frame, shifts it out on the management data line and, for reads, releases the line and shifts the answer back in. When the frame ends it clears the start flag by itself and leaves the captured data and a response flag in the same word.

A control word enables the controller and sets the management clock divider; its top bit reads back whether the frame engine is idle. A link word keeps one bit per PHY address. Each bit is refreshed from a bit of the PHY status register whenever software performs an acknowledged read of that register. The bidirectional pad is outside the block: the block drives separate output-value, output-enable and input signals.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control word (reg_addr 0) reads 0x80000000 (idle bit 31 set, enable bit 30 clear, divider 0), the access word (reg_addr 1) and the link word (reg_addr 2) read 0, and mdc and mdio_oe are low.
- R2: While enabled, mdc toggles once every divider+1 clock cycles, where the divider is held in the low DIV_W bits of the control word. While disabled, mdc stays low.
- R3: Writing the access word with bit 31 set while the controller is enabled and idle starts a frame. Bit 31 then reads 1 and control bit 31 reads 0 until the frame ends, and bit 31 then clears by itself.
- R4: A read frame (access bit 30 = 0) sends 32 ones, start code 01, opcode 10, the PHY address from access bits 20:16 and then the register address from access bits 25:21, each MSB first. It then drops mdio_oe for the two turnaround bits and the 16 data bits.
- R5: A write frame (access bit 30 = 1) sends the same preamble, start code and addresses with opcode 01, then turnaround 10, then access bits 15:0 MSB first, with mdio_oe high for the whole frame.
- R6: After a read, access bit 29 is 1 exactly when mdio_i was 0 at the second turnaround bit, and bits 15:0 hold the 16 bits sampled MSB first. After a write, bit 29 is 0 and bits 15:0 keep the written data.
- R7: A write to the access word while its bit 31 is set is ignored, including a write in the cycle in which bit 31 clears.
- R8: A write to the access word with bit 31 set while the control enable bit is 0 starts no frame, and bit 31 reads 0. The other fields of that write are still stored.
- R9: A write to the control word while a frame is in progress is ignored.
- R10: After an acknowledged read of register address 1, link bit n (n = PHY address) equals read data bit 2. Unacknowledged reads, reads of other registers and writes leave the link word unchanged.
- R11: mdio_o changes only together with a falling mdc edge, and input is sampled on rising mdc edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 access, 2 link |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The sharp collision is a software write to the access word landing on the very edge where the engine finishes and the start flag self-clears. At that edge the old flag is still set, so the write must be dropped rather than treated as a new launch. The bench tracks the frame bit by bit through its PHY model, and after the last falling mdc edge it counts divider+2 system clocks and places the access write exactly on the completion edge. It then checks that the stored PHY and register fields still belong to the finished frame, that no second frame follows, and that the flag is clear. The same window is used to show that a control write arriving mid-frame leaves the divider and enable unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   // register select codes on reg_addr
   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_ACC  = 2'd1;
   localparam logic [1:0] SEL_LINK = 2'd2;

   // control word bit positions
   localparam int CTRL_IDLE_BIT = 31;
   localparam int CTRL_EN_BIT   = 30;

   // access word layout, MSB first
   typedef struct packed {
      logic        go;
      logic        wr;
      logic        ack;
      logic [2:0]  rsvd;
      logic [4:0]  regad;
      logic [4:0]  phyad;
      logic [15:0] data;
   } acc_word_t;

   localparam int NUM_PHY = 32;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap      = en && (cnt_q == div);
   assign rise_tick = wrap && !mdc;
   assign fall_tick = wrap &&  mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_MDC_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !mdc); // R2

   AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick |=> mdc); // R2

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        op_wr,
   input  logic [4:0]  phyad,
   input  logic [4:0]  regad,
   input  logic [15:0] wdata,
   input  logic        rise_tick,
   input  logic        fall_tick,
   input  logic        mdio_i,
   output logic        busy,
   output logic        done,
   output logic        ack,
   output logic [15:0] rdata,
   output logic        mdio_o,
   output logic        mdio_oe
);

   localparam int FRAME_W = PRE_LEN + 32;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam int TA2_POS = PRE_LEN + 15;
   localparam int DAT_POS = PRE_LEN + 16;
   localparam int LAST    = FRAME_W - 1;
   localparam int RD_DRV  = PRE_LEN + 14;

   generate
      if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_bad_pre
         $error("mdio_frame_eng: PRE_LEN must be 1..32");
      end
   endgenerate

   logic [FRAME_W-1:0] frame_v, oe_v;
   logic [FRAME_W-1:0] sr_q, oe_sr_q;
   logic [IDX_W-1:0]   idx_q;
   logic               started_q, fin_q, op_wr_q, ack_q;
   logic [15:0]        rd_sr_q;

   always_comb begin
      frame_v = {{PRE_LEN{1'b1}}, 2'b01,
                 (op_wr ? 2'b01 : 2'b10), phyad, regad,
                 (op_wr ? 2'b10 : 2'b11),
                 (op_wr ? wdata : 16'hFFFF)};
      if (op_wr) oe_v = '1;
      else       oe_v = {{RD_DRV{1'b1}}, {(FRAME_W-RD_DRV){1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         started_q <= 1'b0;
         fin_q     <= 1'b0;
         idx_q     <= '0;
         sr_q      <= '0;
         oe_sr_q   <= '0;
         op_wr_q   <= 1'b0;
         ack_q     <= 1'b0;
         rd_sr_q   <= '0;
         mdio_o    <= 1'b1;
         mdio_oe   <= 1'b0;
      end else if (start) begin
         busy      <= 1'b1;
         started_q <= 1'b0;
         fin_q     <= 1'b0;
         idx_q     <= '0;
         sr_q      <= frame_v;
         oe_sr_q   <= oe_v;
         op_wr_q   <= op_wr;
         ack_q     <= 1'b0;
         rd_sr_q   <= '0;
      end else if (fin_q) begin
         busy      <= 1'b0;
         started_q <= 1'b0;
         fin_q     <= 1'b0;
         mdio_oe   <= 1'b0;
      end else if (busy) begin
         if (fall_tick) begin
            if (!started_q) begin
               started_q <= 1'b1;
               idx_q     <= '0;
            end else begin
               idx_q     <= idx_q + 1'b1;
            end
            mdio_o  <= sr_q[FRAME_W-1];
            mdio_oe <= oe_sr_q[FRAME_W-1];
            sr_q    <= {sr_q[FRAME_W-2:0], 1'b0};
            oe_sr_q <= {oe_sr_q[FRAME_W-2:0], 1'b0};
         end else if (rise_tick && started_q) begin
            if (!op_wr_q) begin
               if (idx_q == IDX_W'(TA2_POS)) ack_q <= ~mdio_i;
               if (idx_q >= IDX_W'(DAT_POS)) rd_sr_q <= {rd_sr_q[14:0], mdio_i};
            end
            if (idx_q == IDX_W'(LAST)) fin_q <= 1'b1;
         end
      end
   end

   assign done  = fin_q;
   assign ack   = ack_q;
   assign rdata = rd_sr_q;

   AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe); // R4

   AST_WRITE_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && started_q && op_wr_q) |-> mdio_oe); // R5

   AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rise_tick)); // R11

endmodule

// File: rtl/mdio_link_track.sv
module mdio_link_track #(
   parameter int NPHY = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd,
   input  logic [4:0]      phyad,
   input  logic            val,
   output logic [NPHY-1:0] link
);

   generate
      for (genvar g = 0; g < NPHY; g++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        link[g] <= 1'b0;
            else if (upd && (phyad == 5'(g)))  link[g] <= val;
         end
      end
   endgenerate

   AST_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(link)); // R10

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter int PRE_LEN    = 32,
   parameter int LINK_REGAD = 1,
   parameter int LINK_BIT   = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("mdio_mgmt_ctrl: DIV_W must be 1..16");
      end
      if (LINK_BIT < 0 || LINK_BIT > 15 || LINK_REGAD < 0 || LINK_REGAD > 31) begin : g_bad_link
         $error("mdio_mgmt_ctrl: link source out of range");
      end
   endgenerate

   logic             en_q;
   logic [DIV_W-1:0] div_q;
   acc_word_t        acc_q, acc_in;
   logic [NUM_PHY-1:0] link_w;

   logic        rise_tick, fall_tick;
   logic        eng_busy, eng_done, eng_ack;
   logic [15:0] eng_rdata;
   logic        ctrl_wr, acc_wr, launch, link_upd;

   assign acc_in  = acc_word_t'(reg_wdata);
   assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL) && !eng_busy;
   assign acc_wr  = reg_wr && (reg_addr == SEL_ACC) && !acc_q.go;
   assign launch  = acc_wr && acc_in.go && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         div_q <= '0;
      end else if (ctrl_wr) begin
         en_q  <= reg_wdata[CTRL_EN_BIT];
         div_q <= reg_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (acc_wr) begin
         acc_q       <= acc_in;
         acc_q.go    <= launch;
         acc_q.ack   <= 1'b0;
         acc_q.rsvd  <= '0;
      end else if (eng_done) begin
         acc_q.go  <= 1'b0;
         acc_q.ack <= eng_ack;
         if (!acc_q.wr) acc_q.data <= eng_rdata;
      end
   end

   mdio_clk_div #(.DIV_W(DIV_W)) i_clk_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .div       (div_q),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_eng #(.PRE_LEN(PRE_LEN)) i_frame_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (launch),
      .op_wr     (acc_in.wr),
      .phyad     (acc_in.phyad),
      .regad     (acc_in.regad),
      .wdata     (acc_in.data),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .busy      (eng_busy),
      .done      (eng_done),
      .ack       (eng_ack),
      .rdata     (eng_rdata),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe)
   );

   assign link_upd = eng_done && !acc_q.wr && eng_ack && (acc_q.regad == 5'(LINK_REGAD));

   mdio_link_track #(.NPHY(NUM_PHY)) i_link (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (link_upd),
      .phyad (acc_q.phyad),
      .val   (eng_rdata[LINK_BIT]),
      .link  (link_w)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         SEL_CTRL: begin
            reg_rdata[CTRL_IDLE_BIT] = ~eng_busy;
            reg_rdata[CTRL_EN_BIT]   = en_q;
            reg_rdata[DIV_W-1:0]     = div_q;
         end
         SEL_ACC:  reg_rdata = acc_q;
         SEL_LINK: reg_rdata = link_w;
         default:  reg_rdata = '0;
      endcase
   end

   AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> acc_q.go); // R3

   AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !acc_q.go); // R3

   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SEL_ACC && acc_q.go) |=>
      (acc_q.phyad == $past(acc_q.phyad) && acc_q.regad == $past(acc_q.regad)
       && acc_q.wr == $past(acc_q.wr))); // R7

   AST_NO_RUN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !eng_busy); // R8

   AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |=> ($stable(div_q) && $stable(en_q))); // R9

   AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $fell(mdc)); // R11

endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int PRE       = 32;
   localparam int FW        = PRE + 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // PHY model state
   logic [FW-1:0] exp_o, exp_oe;
   bit            rsp_ack;
   logic [15:0]   rsp_data;
   int            cur_div = 0;
   bit            phy_act = 0;
   int            phy_pos = 0;
   int            frame_err = 0, per_err = 0, stab_err = 0, frames_done = 0;
   int            clk_since = 0;
   logic          mdc_q = 1'b0, fall_val = 1'b1;
   bit            last_fall = 0;
   logic [31:0]   link_m = '0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] mk_frame(bit wr, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
      return {{PRE{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
   endfunction

   function automatic logic [FW-1:0] mk_oe(bit wr);
      return wr ? {FW{1'b1}} : {{(PRE+14){1'b1}}, 18'b0};
   endfunction

   always @(negedge clk) begin
      clk_since++;
      if (mdc !== mdc_q) begin
         if (phy_act && phy_pos > 0 && clk_since != cur_div + 1) per_err++;
         clk_since = 0;
         if (!mdc) begin
            if (!phy_act) begin
               if (mdio_oe) begin phy_act = 1; phy_pos = 0; end
            end else phy_pos++;
            if (phy_act) begin
               fall_val = mdio_o;
               if (phy_pos == PRE + 15)      mdio_i = rsp_ack ? 1'b0 : 1'b1;
               else if (phy_pos >= PRE + 16) mdio_i = rsp_data[15 - (phy_pos - PRE - 16)];
               else                          mdio_i = 1'b1;
               if (phy_pos == FW - 1) last_fall = 1;
            end
         end else if (phy_act) begin
            if (mdio_oe !== exp_oe[FW-1-phy_pos]) frame_err++;
            else if (mdio_oe && mdio_o !== exp_o[FW-1-phy_pos]) frame_err++;
            if (mdio_o !== fall_val) stab_err++;
            if (phy_pos == FW - 1) begin
               phy_act = 0; frames_done++; mdio_i = 1'b1;
            end
         end
         mdc_q = mdc;
      end
   end

   task automatic reg_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      #1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      #1; reg_addr = a;
      #1; d = reg_rdata;
   endtask

   task automatic wait_go_clear();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         reg_read(2'd1, v);
         if (!v[31]) break;
      end
   endtask

   task automatic set_ctrl(bit en, int dv);
      reg_write(2'd0, {1'b0, en, 22'b0, 8'(dv)});
      cur_div = dv;
   endtask

   task automatic arm(bit wr, logic [4:0] phy, logic [4:0] ra, logic [15:0] wd, bit ack, logic [15:0] rd);
      exp_o = mk_frame(wr, phy, ra, wd); exp_oe = mk_oe(wr);
      rsp_ack = ack; rsp_data = rd;
      frame_err = 0; per_err = 0; stab_err = 0; last_fall = 0;
   endtask

   task automatic post_checks(string tag, bit wr, logic [4:0] phy, logic [4:0] ra,
                              logic [15:0] wd, bit ack, logic [15:0] rd, int fb);
      logic [31:0] v;
      bit ea;
      ea = wr ? 1'b0 : ack;
      chk(wr ? "R5" : "R4", {tag, " frame bits"}, frame_err, 0);
      chk("R2", {tag, " mdc half period"}, per_err, 0);
      chk("R11", {tag, " mdio_o stable over high mdc"}, stab_err, 0);
      chk("R3", {tag, " one frame per launch"}, frames_done - fb, 1);
      reg_read(2'd1, v);
      if (wr || ack)
         chk("R6", {tag, " access word"}, v, {1'b0, wr, ea, 3'b0, ra, phy, (wr ? wd : rd)});
      else
         chk("R6", {tag, " access word no ack"}, {v[31:16], 16'h0}, {1'b0, wr, 1'b0, 3'b0, ra, phy, 16'h0});
      if (!wr && ack && ra == 5'd1) link_m[phy] = rd[2];
      reg_read(2'd2, v);
      chk("R10", {tag, " link word"}, v, link_m);
   endtask

   task automatic run_xact(string tag, bit wr, logic [4:0] phy, logic [4:0] ra,
                           logic [15:0] wd, bit ack, logic [15:0] rd);
      logic [31:0] v;
      int fb;
      fb = frames_done;
      arm(wr, phy, ra, wd, ack, rd);
      reg_write(2'd1, {1'b1, wr, 1'b0, 3'b0, ra, phy, wd});
      reg_read(2'd0, v);
      chk("R3", {tag, " idle bit low while busy"}, {31'b0, v[31]}, 0);
      wait_go_clear();
      post_checks(tag, wr, phy, ra, wd, ack, rd, fb);
   endtask

   initial begin
      logic [31:0] v;
      int fb;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      reg_read(2'd0, v); chk("R1", "control after reset", v, 32'h8000_0000);
      reg_read(2'd1, v); chk("R1", "access after reset", v, 32'h0);
      reg_read(2'd2, v); chk("R1", "link after reset", v, 32'h0);
      chk("R1", "mdc/oe after reset", {30'b0, mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8 go while disabled
      fb = frames_done;
      reg_write(2'd1, {1'b1, 1'b1, 1'b0, 3'b0, 5'd9, 5'd3, 16'hA5A5});
      repeat (40) @(negedge clk);
      reg_read(2'd1, v);
      chk("R8", "go dropped while disabled", v, {1'b0, 1'b1, 1'b0, 3'b0, 5'd9, 5'd3, 16'hA5A5});
      chk("R8", "no frame while disabled", {31'b0, mdio_oe}, 0);
      chk("R2", "mdc low while disabled", {31'b0, mdc}, 0);
      reg_read(2'd0, v); chk("R8", "idle while disabled", v, 32'h8000_0000);

      // directed frames
      set_ctrl(1, 3);
      run_xact("rd ack link", 0, 5'd5, 5'd1, 16'h0, 1, 16'h0004);
      run_xact("wr", 1, 5'd17, 5'd30, 16'hC3A5, 0, 16'h0);
      run_xact("rd no ack", 0, 5'd7, 5'd1, 16'h0, 0, 16'h0004);
      run_xact("rd other reg", 0, 5'd6, 5'd2, 16'h0, 1, 16'h0004);
      run_xact("rd link clear", 0, 5'd5, 5'd1, 16'h0, 1, 16'hFFFB);

      // R7 mid-frame access write and R9 control write while busy
      fb = frames_done;
      arm(0, 5'd12, 5'd1, 16'h0, 1, 16'h1234);
      reg_write(2'd1, {1'b1, 1'b0, 1'b0, 3'b0, 5'd1, 5'd12, 16'h0});
      repeat (30) @(negedge clk);
      reg_write(2'd1, {1'b1, 1'b1, 1'b0, 3'b0, 5'd7, 5'd2, 16'hFFFF});
      reg_write(2'd0, {1'b0, 1'b1, 22'b0, 8'd7});
      wait_go_clear();
      reg_read(2'd0, v); chk("R9", "control unchanged after busy write", v, 32'hC000_0003);
      post_checks("R7 mid-frame", 0, 5'd12, 5'd1, 16'h0, 1, 16'h1234, fb);

      // R7 access write on the completion edge
      set_ctrl(1, 2);
      fb = frames_done;
      arm(1, 5'd21, 5'd4, 16'h5A0F, 0, 16'h0);
      reg_write(2'd1, {1'b1, 1'b1, 1'b0, 3'b0, 5'd4, 5'd21, 16'h5A0F});
      wait (last_fall);
      repeat (cur_div + 1) @(negedge clk);
      #1; reg_wr = 1'b1; reg_addr = 2'd1;
      reg_wdata = {1'b1, 1'b0, 1'b0, 3'b0, 5'd1, 5'd9, 16'h0};
      @(negedge clk); reg_wr = 1'b0;
      repeat (60) @(negedge clk);
      post_checks("R7 completion edge", 1, 5'd21, 5'd4, 16'h5A0F, 0, 16'h0, fb);

      // random frames
      for (int n = 0; n < 12; n++) begin
         int dv;
         bit wr, ak;
         logic [4:0] ph, ra;
         logic [15:0] wd, rd;
         dv = int'($urandom_range(0, 4));
         wr = 1'($urandom_range(0, 1));
         ak = ($urandom_range(0, 3) != 0);
         ph = 5'($urandom); ra = 5'($urandom_range(0, 3));
         wd = 16'($urandom); rd = 16'($urandom);
         set_ctrl(1, dv);
         run_xact("random", wr, ph, ra, wd, ak, rd);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule